// File: doc/BRIEF.md
# Mixed-Length Instruction Parcel Sequencer

The sequencer takes 60-bit instruction words over a valid/ready handshake and hands out one decoded instruction per accepted transfer. Each word is split into four 15-bit parcels, and parcels are used starting from the most significant end. An instruction takes one parcel (short form) or two adjacent parcels (long form). The length is decided by the 6-bit opcode at the top of the instruction, looked up in a parameter bitmask.

A short instruction yields an opcode and three 3-bit register fields. A long instruction yields an opcode, two register fields and an 18-bit constant. A long instruction never spans two words. A long opcode found in the last parcel of a word therefore cannot be issued. That parcel is discarded, an alignment error is flagged for that cycle, and decoding restarts at the first parcel of the next word. When the downstream side is not ready, the sequencer holds its place.

Top module: `parcel_seq`

## Requirements
- R1: Parcels of a word are issued in order from bits 59:45 down to bits 14:0. A new word always starts at bits 59:45.
- R2: A short instruction in parcel bits p[14:0] gives op_o=p[14:9], rd_o=p[8:6], ra_o=p[5:3], rb_o=p[2:0], with long_o=0.
- R3: An opcode is long when bit `op` of LONG_OP_MASK is set. With the defaults, the long opcodes are 0x04 to 0x07 and 0x30 to 0x37. A long instruction in the 30 bits l[29:0] gives op_o=l[29:24], rd_o=l[23:21], ra_o=l[20:18], imm_o=l[17:0], with long_o=1.
- R4: A long instruction may start in parcel 0, 1 or 2. It consumes two parcels.
- R5: A long opcode in the last parcel produces no instruction. align_err_o is high for exactly that one cycle and word_ready_o is high in the same cycle. The next instruction comes from parcel 0 of the next word.
- R6: word_ready_o is high when no word is held. It is also high in the cycle in which the last instruction of the held word is accepted, so a new word can load in that same cycle. Otherwise it is low.
- R7: While instr_valid_o is high and instr_ready_i is low, instr_valid_o stays high and all instruction fields stay unchanged in the next cycle.
- R8: During reset and right after it, instr_valid_o and align_err_o are low and word_ready_o is high.
- R9: rb_o is zero for long instructions. imm_o is zero for short instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Instruction word offered |
| word_i | input | 60 | Instruction word |
| word_ready_o | output | 1 | Word accepted when high together with word_valid_i |
| instr_valid_o | output | 1 | Decoded instruction available |
| instr_ready_i | input | 1 | Downstream takes the instruction |
| op_o | output | 6 | Opcode |
| rd_o | output | 3 | Result register field |
| ra_o | output | 3 | First operand register field |
| rb_o | output | 3 | Second operand register field (short form) |
| imm_o | output | 18 | Constant (long form) |
| long_o | output | 1 | Instruction is the long form |
| align_err_o | output | 1 | Long opcode found in the last parcel and discarded |

## Verification
Two events can land in the same cycle: a word is used up (either its final instruction is accepted or a last-parcel long opcode is discarded), and the next word is loaded. The bench keeps words queued and switches instr_ready_i randomly, so end-of-word handouts and discards line up with pending words. A behavioural model tracks the word position and predicts word_ready_o, the alignment flag and every field in each cycle. A refill that goes missing or comes one cycle late shows up as a mismatch on word_ready_o or on the next instruction.

// File: rtl/parcel_seq_pkg.sv
package parcel_seq_pkg;
  typedef enum logic {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } len_e;
endpackage

// File: rtl/parcel_decode.sv
module parcel_decode
  import parcel_seq_pkg::*;
#(
  parameter int PARCEL_W = 15,
  parameter int PARCELS  = 4,
  parameter int OP_W     = 6,
  parameter int REG_W    = 3,
  parameter logic [(1<<OP_W)-1:0] LONG_OP_MASK = 64'h00FF_0000_0000_00F0,
  parameter int IDX_W    = $clog2(PARCELS)
) (
  input  logic [PARCEL_W*PARCELS-1:0]          word_i,
  input  logic [IDX_W-1:0]                     idx_i,
  output logic [OP_W-1:0]                      op_o,
  output logic [REG_W-1:0]                     rd_o,
  output logic [REG_W-1:0]                     ra_o,
  output logic [REG_W-1:0]                     rb_o,
  output logic [2*PARCEL_W-OP_W-2*REG_W-1:0]   imm_o,
  output len_e                                 len_o
);
  localparam int WORD_W = PARCEL_W * PARCELS;
  localparam int IMM_W  = 2 * PARCEL_W - OP_W - 2 * REG_W;

  logic [PARCEL_W-1:0]   parcel [PARCELS+1];
  logic [PARCEL_W-1:0]   cur, nxt;
  logic [2*PARCEL_W-1:0] long_w;
  logic [IDX_W:0]        cur_idx, nxt_idx;

  // slot PARCELS is a zero pad so a last-slot lookahead stays in range
  for (genvar k = 0; k < PARCELS; k++) begin : g_slot
    assign parcel[k] = word_i[WORD_W-1-k*PARCEL_W -: PARCEL_W];
  end
  assign parcel[PARCELS] = '0;

  assign cur_idx = {1'b0, idx_i};
  assign nxt_idx = cur_idx + 1'b1;
  assign cur     = parcel[cur_idx];
  assign nxt     = parcel[nxt_idx];
  assign long_w  = {cur, nxt};

  assign op_o  = cur[PARCEL_W-1 -: OP_W];
  assign len_o = LONG_OP_MASK[op_o] ? LEN_LONG : LEN_SHORT;
  assign rd_o  = cur[PARCEL_W-OP_W-1 -: REG_W];
  assign ra_o  = cur[PARCEL_W-OP_W-REG_W-1 -: REG_W];

  always_comb begin
    if (len_o == LEN_LONG) begin
      rb_o  = '0;
      imm_o = long_w[IMM_W-1:0];
    end else begin
      rb_o  = cur[REG_W-1:0];
      imm_o = '0;
    end
  end
endmodule

// File: rtl/parcel_ctrl.sv
module parcel_ctrl
  import parcel_seq_pkg::*;
#(
  parameter int PARCELS = 4,
  parameter int WORD_W  = 60,
  parameter int IDX_W   = $clog2(PARCELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              instr_ready_i,
  input  len_e              len_i,
  output logic [WORD_W-1:0] word_q_o,
  output logic [IDX_W-1:0]  idx_q_o,
  output logic              word_ready_o,
  output logic              instr_valid_o,
  output logic              drop_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PARCELS - 1);
  localparam logic [IDX_W:0]   END_POS  = (IDX_W+1)'(PARCELS);

  logic              have_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W:0]    span, nxt_pos;
  logic              fire, done, load;

  assign span    = (len_i == LEN_LONG) ? (IDX_W+1)'(2) : (IDX_W+1)'(1);
  assign nxt_pos = {1'b0, idx_q} + span;

  // long opcode with no room left in the word: discard and realign
  assign drop_o        = have_q && (len_i == LEN_LONG) && (idx_q == LAST_IDX);
  assign instr_valid_o = have_q && !drop_o;
  assign fire          = instr_valid_o && instr_ready_i;
  assign done          = drop_o || (fire && (nxt_pos >= END_POS));
  assign word_ready_o  = !have_q || done;
  assign load          = word_valid_i && word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      have_q <= 1'b1;
      word_q <= word_i;
      idx_q  <= '0;
    end else if (done) begin
      have_q <= 1'b0;
    end else if (fire) begin
      idx_q  <= nxt_pos[IDX_W-1:0];
    end
  end

  assign word_q_o = word_q;
  assign idx_q_o  = idx_q;
endmodule

// File: rtl/parcel_seq.sv
module parcel_seq
  import parcel_seq_pkg::*;
#(
  parameter int PARCEL_W = 15,
  parameter int PARCELS  = 4,
  parameter int OP_W     = 6,
  parameter int REG_W    = 3,
  parameter logic [(1<<OP_W)-1:0] LONG_OP_MASK = 64'h00FF_0000_0000_00F0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 word_valid_i,
  input  logic [PARCEL_W*PARCELS-1:0]          word_i,
  output logic                                 word_ready_o,
  output logic                                 instr_valid_o,
  input  logic                                 instr_ready_i,
  output logic [OP_W-1:0]                      op_o,
  output logic [REG_W-1:0]                     rd_o,
  output logic [REG_W-1:0]                     ra_o,
  output logic [REG_W-1:0]                     rb_o,
  output logic [2*PARCEL_W-OP_W-2*REG_W-1:0]   imm_o,
  output logic                                 long_o,
  output logic                                 align_err_o
);
  localparam int WORD_W = PARCEL_W * PARCELS;
  localparam int IDX_W  = $clog2(PARCELS);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  len_e              len;

  parcel_decode #(
    .PARCEL_W(PARCEL_W), .PARCELS(PARCELS), .OP_W(OP_W), .REG_W(REG_W),
    .LONG_OP_MASK(LONG_OP_MASK), .IDX_W(IDX_W)
  ) i_decode (
    .word_i(word_q), .idx_i(idx_q), .op_o(op_o), .rd_o(rd_o), .ra_o(ra_o),
    .rb_o(rb_o), .imm_o(imm_o), .len_o(len)
  );

  parcel_ctrl #(
    .PARCELS(PARCELS), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_valid_i(word_valid_i),
    .word_i(word_i), .instr_ready_i(instr_ready_i), .len_i(len),
    .word_q_o(word_q), .idx_q_o(idx_q), .word_ready_o(word_ready_o),
    .instr_valid_o(instr_valid_o), .drop_o(align_err_o)
  );

  assign long_o = (len == LEN_LONG);
endmodule

// File: rtl/parcel_seq_chk.sv
module parcel_seq_chk #(
  parameter int PARCEL_W = 15,
  parameter int PARCELS  = 4,
  parameter int OP_W     = 6,
  parameter int REG_W    = 3
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               word_valid_i,
  input logic                               word_ready_o,
  input logic                               instr_valid_o,
  input logic                               instr_ready_i,
  input logic [OP_W-1:0]                    op_o,
  input logic [REG_W-1:0]                   rd_o,
  input logic [REG_W-1:0]                   ra_o,
  input logic [REG_W-1:0]                   rb_o,
  input logic [2*PARCEL_W-OP_W-2*REG_W-1:0] imm_o,
  input logic                               long_o,
  input logic                               align_err_o
);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !instr_ready_i |=> instr_valid_o && $stable(op_o) &&
      $stable(rd_o) && $stable(ra_o) && $stable(rb_o) && $stable(imm_o) && $stable(long_o));

  // R6
  stall_no_refill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !instr_ready_i |-> !word_ready_o);

  // R6
  idle_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_o |-> word_ready_o);

  // R5
  drop_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !instr_valid_o && word_ready_o);

  // R5
  drop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> !align_err_o);

  // R9
  long_rb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && long_o |-> rb_o == '0);

  // R9
  short_imm_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !long_o |-> imm_o == '0);
endmodule

bind parcel_seq parcel_seq_chk i_parcel_seq_chk (.*);

// File: tb/test_parcel_seq.sv
module test_parcel_seq;
  localparam logic [63:0] LMASK = 64'h00FF_0000_0000_00F0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [59:0] word_i = '0;
  logic        instr_ready_i = 1'b0;
  logic        word_ready_o, instr_valid_o, long_o, align_err_o;
  logic [5:0]  op_o;
  logic [2:0]  rd_o, ra_o, rb_o;
  logic [17:0] imm_o;

  always #2 clk = ~clk;

  parcel_seq i_parcel_seq (
    .clk_i(clk), .rst_ni(rst_ni), .word_valid_i(word_valid_i), .word_i(word_i),
    .word_ready_o(word_ready_o), .instr_valid_o(instr_valid_o),
    .instr_ready_i(instr_ready_i), .op_o(op_o), .rd_o(rd_o), .ra_o(ra_o),
    .rb_o(rb_o), .imm_o(imm_o), .long_o(long_o), .align_err_o(align_err_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [59:0] words[$];
  logic [59:0] mword = '0;
  bit          mhave = 0;
  int          mpos = 0;
  int          ready_mode = 0;   // 0 always, 1 random, 2 held low
  bit          in_reset = 1;

  function automatic logic [14:0] sp(int op, int rd, int ra, int rb);
    return {6'(op), 3'(rd), 3'(ra), 3'(rb)};
  endfunction

  function automatic logic [29:0] lp(int op, int rd, int ra, int imm);
    return {6'(op), 3'(rd), 3'(ra), 18'(imm)};
  endfunction

  function automatic logic [14:0] mp(int k);
    if (k > 3) return '0;
    return mword[59-15*k -: 15];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [59:0] rand_word();
    logic [59:0] w;
    for (int k = 0; k < 4; k++) begin
      logic [14:0] p;
      p = 15'($urandom);
      if ($urandom_range(0, 2) == 0)
        p[14:9] = ($urandom_range(0, 1) == 0) ? 6'(4 + $urandom_range(0, 3)) : 6'(48 + $urandom_range(0, 7));
      w[59-15*k -: 15] = p;
    end
    return w;
  endfunction

  task automatic step();
    logic [14:0] p, q;
    bit lng, drop, ev, last, ewr;
    int len;
    string ftag;
    @(negedge clk);
    word_valid_i = (words.size() > 0) && (ready_mode != 1 || $urandom_range(0, 3) != 0);
    word_i = (words.size() > 0) ? words[0] : 60'(0);
    instr_ready_i = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
    #1;
    p = mp(mpos);
    lng = LMASK[p[14:9]];
    drop = mhave && lng && (mpos == 3);
    ev = mhave && !drop;
    len = lng ? 2 : 1;
    last = (mpos + len) >= 4;
    ewr = !mhave || drop || (ev && instr_ready_i && last);
    if (in_reset) begin
      chk("R8", "instr_valid_o", 32'(instr_valid_o), 0);
      chk("R8", "align_err_o", 32'(align_err_o), 0);
      chk("R8", "word_ready_o", 32'(word_ready_o), 1);
    end else begin
      chk(ready_mode == 2 ? "R7" : "R6", "instr_valid_o", 32'(instr_valid_o), 32'(ev));
      chk("R6", "word_ready_o", 32'(word_ready_o), 32'(ewr));
      chk("R5", "align_err_o", 32'(align_err_o), 32'(drop));
      if (ev) begin
        if (ready_mode == 2) ftag = "R7";
        else if (lng) ftag = (mpos == 2) ? "R4" : "R3";
        else ftag = (mpos > 0) ? "R1" : "R2";
        chk(ftag, "op_o", 32'(op_o), 32'(p[14:9]));
        chk(ftag, "rd_o", 32'(rd_o), 32'(p[8:6]));
        chk(ftag, "ra_o", 32'(ra_o), 32'(p[5:3]));
        chk(ftag, "long_o", 32'(long_o), 32'(lng));
        if (lng) begin
          q = mp(mpos + 1);
          chk("R9", "rb_o", 32'(rb_o), 0);
          chk(ftag, "imm_o", 32'(imm_o), 32'({p[2:0], q}));
        end else begin
          chk(ftag, "rb_o", 32'(rb_o), 32'(p[2:0]));
          chk("R9", "imm_o", 32'(imm_o), 0);
        end
      end
    end
    @(posedge clk);
    if (!in_reset) begin
      if (word_valid_i && ewr) begin
        mword = word_i;
        void'(words.pop_front());
        mpos = 0;
        mhave = 1;
      end else if (drop || (ev && instr_ready_i && last)) begin
        mhave = 0;
      end else if (ev && instr_ready_i) begin
        mpos += len;
      end
    end
  endtask

  initial begin
    repeat (3) step();
    @(negedge clk);
    rst_ni = 1'b1;
    in_reset = 0;
    repeat (2) step();                      // R8: idle after reset
    // R1 R2: four short forms
    words.push_back({sp(1, 1, 2, 3), sp(2, 4, 5, 6), sp(3, 7, 0, 1), sp(16, 2, 2, 2)});
    // R3: long at parcel 0
    words.push_back({lp(4, 1, 2, 'h2ABCD), sp(1, 3, 3, 3), sp(2, 5, 6, 7)});
    // R3: long at parcel 1
    words.push_back({sp(9, 1, 1, 1), lp(48, 3, 4, 'h12345), sp(10, 0, 7, 0)});
    // R4: long at parcel 2
    words.push_back({sp(11, 2, 3, 4), sp(12, 5, 6, 7), lp(55, 6, 1, 'h3FFFF)});
    // R5: long opcode in last parcel is discarded
    words.push_back({sp(13, 1, 0, 1), sp(14, 2, 0, 2), sp(15, 3, 0, 3), sp(5, 7, 7, 7)});
    words.push_back({lp(6, 2, 3, 'h00001), lp(7, 4, 5, 'h20000)});
    words.push_back({sp(55, 1, 2, 3), sp(20, 1, 1, 1), sp(21, 2, 2, 2), sp(22, 3, 3, 3)});
    repeat (30) step();
    // R7: stall with a word queued behind
    words.push_back({sp(30, 1, 2, 3), lp(49, 2, 3, 'h0ABCD), sp(31, 4, 5, 6)});
    words.push_back(rand_word());
    step();
    ready_mode = 2;
    repeat (6) step();
    ready_mode = 0;
    repeat (10) step();
    // random traffic: refills collide with end-of-word handouts and discards
    ready_mode = 1;
    for (int n = 0; n < 4000; n++) begin
      if (words.size() < 3) words.push_back(rand_word());
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule